// File: doc/BRIEF.md
# Colour Lookup Access Arbiter

This block owns a 256-entry colour lookup memory. The display pipeline reads it all the time through a registered read port. The host CPU can take the memory for itself. The host first sets a request flag. It then polls a grant flag. While it holds the grant it writes entries. When it is done it clears the request, and the display gets the memory back.

A grant is only given while the display is in vertical blanking, or straight away when the display is switched off. This keeps the host from disturbing a visible frame. While the grant is held, the display port keeps presenting the last colour it latched and does not touch the memory. Host writes outside a grant are dropped.

Top module: `palArb`

## Requirements
- R1: After reset the status outputs show request 0 and grant 0, and `dispRdData` is 0.
- R2: A control write (`ctrlWr` high) loads `ctrlReq` into the request flag. The flag appears on `statusBits[0]` in the next cycle. `statusBits[1]` is the grant flag.
- R3: The grant is set one cycle after a clock edge at which the request flag is already set and either `vBlank` is high or `displayOn` is low. While `displayOn` is high and `vBlank` is low, the grant is never set.
- R4: Once set, the grant stays high for as long as the request flag stays set, even after vertical blanking ends.
- R5: A control write with `ctrlReq` = 0 clears the request flag and the grant at the same clock edge.
- R6: A host write (`palWrEn`) made while granted stores `palWrData` ANDed with the parameter `PAL_MASK` (default 24'hFCFCFC) at `palWrAddr`. The entry layout is red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R7: A host write made while the grant is low leaves the memory unchanged.
- R8: While the grant is low, a display read (`dispRdEn`) of address A shows the stored entry A on `dispRdData` in the next cycle.
- R9: While the grant is high, `dispRdData` holds its last latched value and display reads have no effect.
- R10: A host write in the same cycle as the releasing control write is still stored, because the grant is still high during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| displayOn | input | 1 | Display scan is running |
| vBlank | input | 1 | Vertical blanking interval |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlReq | input | 1 | Request value written by the control write |
| statusBits | output | 2 | Bit 0 is the request flag, bit 1 is the grant flag |
| palWrEn | input | 1 | Host palette write strobe |
| palWrAddr | input | 8 | Host palette write address |
| palWrData | input | 24 | Host colour word |
| dispRdEn | input | 1 | Display read strobe |
| dispRdAddr | input | 8 | Display read address |
| dispRdData | output | 24 | Latched colour for the display |

## Verification
Two functions of this block can act in the same cycle. The first pair is the release of access and a host palette write. The bench drives the releasing control write and an entry write on the same edge. It then reads the entry back through the display port to judge it: the stored entry must be the masked new word. The second pair is a display read and an active grant. The bench issues a display read while the grant is held and requires the scoreboard to see the previously latched colour, not the addressed entry.

// File: rtl/palarb_pkg.sv
package palarb_pkg;
  // Strobes sent from the access control to the storage datapath
  typedef struct packed {
    logic memWr;   // host write accepted this cycle
    logic memRd;   // display read allowed this cycle
  } palStrobe_t;
endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import palarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       displayOn,
  input  logic       vBlank,
  input  logic       ctrlWr,
  input  logic       ctrlReq,
  input  logic       hostWrEn,
  input  logic       dispRdEn,
  output logic       reqQ,
  output logic       grantQ,
  output palStrobe_t strobe
);
  logic releaseNow;
  logic safeWindow;

  assign releaseNow = ctrlWr && !ctrlReq;
  assign safeWindow = vBlank || !displayOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      grantQ <= 1'b0;
    end else begin
      if (ctrlWr) reqQ <= ctrlReq;
      if (releaseNow || !reqQ)
        grantQ <= 1'b0;
      else if (safeWindow)
        grantQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.memWr = hostWrEn && grantQ;
    strobe.memRd = dispRdEn && !grantQ;
  end

  // R3: a new grant only follows a safe window with the request already set
  a_r3_grant_in_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantQ) |-> $past(reqQ && (vBlank || !displayOn)));
  // R4: grant held while the request is not withdrawn
  a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ && !(ctrlWr && !ctrlReq)) |=> grantQ);
  // R5: a release write removes the grant at once
  a_r5_release_drop: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !ctrlReq) |=> (!grantQ && !reqQ));
  // R2: control write reaches the request flag
  a_r2_req_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (reqQ == $past(ctrlReq)));
endmodule

// File: rtl/palData.sv
module palData
  import palarb_pkg::*;
#(
  parameter int          ENTRIES  = 256,
  parameter int          COLOR_W  = 24,
  parameter logic [23:0] PAL_MASK = 24'hFCFCFC,
  localparam int         AW       = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strobe,
  input  logic [AW-1:0]      wrAddr,
  input  logic [COLOR_W-1:0] wrData,
  input  logic [AW-1:0]      rdAddr,
  output logic [COLOR_W-1:0] rdData
);
  logic [COLOR_W-1:0] colorMem [ENTRIES];
  logic [COLOR_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (strobe.memWr) colorMem[wrAddr] <= wrData & PAL_MASK[COLOR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdQ <= '0;
    else if (strobe.memRd) rdQ <= colorMem[rdAddr];
  end

  assign rdData = rdQ;

  // R9: without a permitted read the display output does not move
  a_r9_hold_latch: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.memRd |=> $stable(rdQ));
  // R6: stored words never carry bits outside the mask
  a_r6_masked_store: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memRd |=> ((rdQ & ~PAL_MASK[COLOR_W-1:0]) == '0));
endmodule

// File: rtl/palArb.sv
module palArb
  import palarb_pkg::*;
#(
  parameter int          ENTRIES  = 256,
  parameter int          CH_W     = 8,
  parameter logic [23:0] PAL_MASK = 24'hFCFCFC,
  localparam int         AW       = $clog2(ENTRIES),
  localparam int         COLOR_W  = 3 * CH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               displayOn,
  input  logic               vBlank,
  input  logic               ctrlWr,
  input  logic               ctrlReq,
  output logic [1:0]         statusBits,
  input  logic               palWrEn,
  input  logic [AW-1:0]      palWrAddr,
  input  logic [COLOR_W-1:0] palWrData,
  input  logic               dispRdEn,
  input  logic [AW-1:0]      dispRdAddr,
  output logic [COLOR_W-1:0] dispRdData
);
  palStrobe_t strobe;
  logic       reqQ;
  logic       grantQ;

  palCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .displayOn(displayOn), .vBlank(vBlank),
    .ctrlWr(ctrlWr), .ctrlReq(ctrlReq), .hostWrEn(palWrEn),
    .dispRdEn(dispRdEn), .reqQ(reqQ), .grantQ(grantQ), .strobe(strobe)
  );

  palData #(.ENTRIES(ENTRIES), .COLOR_W(COLOR_W), .PAL_MASK(PAL_MASK)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(palWrAddr), .wrData(palWrData),
    .rdAddr(dispRdAddr), .rdData(dispRdData)
  );

  assign statusBits = {grantQ, reqQ};

  // R3: no grant while a visible frame is being scanned
  a_r3_no_grant_visible: assert property (@(posedge clk) disable iff (!rstN)
    (!statusBits[1] && displayOn && !vBlank) |=> !statusBits[1]);
endmodule

// File: tb/palArb_tb_top.sv
module palArb_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic displayOn = 1'b0, vBlank = 1'b0;
  logic ctrlWr = 1'b0, ctrlReq = 1'b0;
  logic [1:0] statusBits;
  logic palWrEn = 1'b0;
  logic [7:0] palWrAddr = '0;
  logic [23:0] palWrData = '0;
  logic dispRdEn = 1'b0;
  logic [7:0] dispRdAddr = '0;
  logic [23:0] dispRdData;

  int total = 0, bad = 0;
  logic [23:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  palArb dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic ctrlWrite(input logic v);
    tick(); ctrlWr = 1'b1; ctrlReq = v;
    tick(); ctrlWr = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [23:0] d);
    tick(); palWrEn = 1'b1; palWrAddr = a; palWrData = d;
    tick(); palWrEn = 1'b0;
  endtask

  // driver: issue a display read and push the expected result
  task automatic dispRead(input logic [7:0] a, input logic [23:0] e, input string tag);
    tick(); dispRdEn = 1'b1; dispRdAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    tick(); dispRdEn = 1'b0;
  endtask

  // monitor: compare the latched colour after each read edge
  initial forever begin
    @(posedge clk);
    if (dispRdEn) begin
      #1;
      if (expQ.size() > 0) begin
        automatic logic [23:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(dispRdData === e, t, dispRdData, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk(statusBits === 2'b00, "R1 status", statusBits, 0);
    chk(dispRdData === 24'h0, "R1 data", dispRdData, 0);

    // display off: grant immediate after request
    tick(); ctrlWr = 1'b1; ctrlReq = 1'b1;
    tick(); ctrlWr = 1'b0;
    chk(statusBits === 2'b01, "R2 request seen", statusBits, 2'b01);
    tick();
    chk(statusBits === 2'b11, "R3 grant display off", statusBits, 2'b11);

    hostWrite(8'd0, 24'h123456);
    hostWrite(8'd1, 24'hFFFFFF);
    hostWrite(8'd2, 24'h0A0B0C);
    // release together with a write (R10)
    tick(); ctrlWr = 1'b1; ctrlReq = 1'b0;
    palWrEn = 1'b1; palWrAddr = 8'd3; palWrData = 24'hABCDEF;
    tick(); ctrlWr = 1'b0; palWrEn = 1'b0;
    chk(statusBits === 2'b00, "R5 release", statusBits, 0);

    displayOn = 1'b1; vBlank = 1'b0;
    hostWrite(8'd1, 24'h000000);   // ignored, R7
    dispRead(8'd0, 24'h103454, "R8 entry0 R6 mask");
    dispRead(8'd1, 24'hFCFCFC, "R7 ungranted write ignored");
    dispRead(8'd2, 24'h08080C, "R6 entry2");
    dispRead(8'd3, 24'hA8CCEC, "R10 write on release");

    // visible frame: request but no grant
    ctrlWrite(1'b1);
    repeat (4) tick();
    chk(statusBits === 2'b01, "R3 no grant visible", statusBits, 2'b01);
    vBlank = 1'b1;
    tick();
    tick();
    chk(statusBits[1] === 1'b1, "R3 grant in blank", statusBits, 2'b11);
    vBlank = 1'b0;
    repeat (3) tick();
    chk(statusBits === 2'b11, "R4 grant held", statusBits, 2'b11);
    dispRead(8'd0, 24'hA8CCEC, "R9 hold during grant");
    hostWrite(8'd2, 24'h555555);
    ctrlWrite(1'b0);
    chk(statusBits === 2'b00, "R5 release again", statusBits, 0);
    dispRead(8'd2, 24'h545454, "R6 granted write stored");
    repeat (3) tick();
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule